// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block sits on the read path of a byte-wide parallel NOR flash model. While an internal program or erase runs, it replaces the plain array byte with a status byte. The status byte carries an inverted-data poll bit, two independent toggle bits and a time-limit flag. Which encoding a read gets depends on the operation in progress, on whether that operation has completed, and on whether the read address falls inside a sector chosen for erase.

The surrounding model supplies several inputs: the operation code, a one-cycle pulse when a new operation begins, the completion and time-limit flags, bit 7 of the byte being programmed, the per-sector erase selection and the array byte at the read address. A one-cycle read strobe, derived from a falling output-enable or chip-enable edge, marks each read. On the strobe the block registers the byte to return. That byte stays on `rd_data` until the next strobe.

Top module: `flash_stat_gen`

## Requirements
- R1: During reset `rd_data` is 0x00, and both toggle bits are cleared, so the first status read of an operation shows 0 in bits 6 and 2.
- R2: With op code 0 (idle), a strobe returns `array_data` unmodified one cycle later. Without a strobe, `rd_data` holds its value whatever the other inputs do.
- R3: With op code 1 (byte program) and `op_done` low, the returned byte is bit 7 = inverse of `prog_msb`, bit 6 = toggle A, bit 5 = `op_timeout`, bit 2 = 1, and bits 4, 3, 1 and 0 = 0.
- R4: With op code 2 (chip erase) or 3 (sector erase) and `op_done` low, the returned byte is bit 7 = 0, bit 6 = toggle A, bit 5 = `op_timeout`, and bits 4, 3, 1 and 0 = 0. Bit 2 is toggle B when the read sector is selected and 1 otherwise. In chip erase every sector counts as selected and `erase_sel` is ignored.
- R5: Toggle A inverts after every strobe at any address while a program or erase is incomplete. This includes the sector-erase wait before erasing begins, which the model signals as sector erase with `op_done` low.
- R6: Toggle B inverts after a strobe only when the read sector (the top 3 bits of the 19-bit `rd_addr`) is selected, and only during an incomplete erase or during suspend. Otherwise it holds its value.
- R7: When a program or erase has `op_done` high, reads return `array_data`, and neither toggle bit changes.
- R8: With op code 4 (erase suspend), a read from a selected sector returns bit 7 = 1, bit 6 = 1, bit 2 = toggle B and all other bits 0. A read from an unselected sector returns `array_data`.
- R9: Bit 5 of every program or erase status byte follows `op_timeout`. It reads 1 when the time limit is exceeded and 0 while the operation runs normally.
- R10: An `op_start` pulse clears both toggle bits. If a strobe arrives in the same cycle, that read still returns the old toggle values, and the clear wins over the advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op | input | 3 | Operation code: 0 idle, 1 program, 2 chip erase, 3 sector erase, 4 erase suspend |
| op_start | input | 1 | One-cycle pulse when a new operation begins |
| op_done | input | 1 | The current program or erase has completed |
| op_timeout | input | 1 | The current operation exceeded its time limit |
| prog_msb | input | 1 | Bit 7 of the byte being programmed |
| rd_strobe | input | 1 | One-cycle pulse per read |
| rd_addr | input | ADDR_W (19) | Read byte address |
| erase_sel | input | NSECT (8) | One bit per sector, set when that sector is chosen for erase |
| array_data | input | 8 | Array byte at `rd_addr` |
| rd_data | output | 8 | Byte returned for the last read |

## Verification
A toggle flip-flop that advanced on the wrong reads, or missed a clear, would show up as bit 6 or bit 2 reading the same value on two consecutive status reads, or a wrong value on the first read after an operation start. It is visible one read after the fault. A wrong sector decode would show bit 2 toggling at an address outside the erase selection, or array data being returned during suspend where status was due. The vector sequence carries the toggle state across operations, so one stale bit corrupts every later expected byte.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;

    typedef enum logic [2:0] {
        OP_IDLE       = 3'd0,
        OP_PROG       = 3'd1,
        OP_CHIP_ERASE = 3'd2,
        OP_SECT_ERASE = 3'd3,
        OP_SUSPEND    = 3'd4
    } emb_op_e;

    localparam int unsigned BIT_POLL  = 7;
    localparam int unsigned BIT_TOG_A = 6;
    localparam int unsigned BIT_TMO   = 5;
    localparam int unsigned BIT_TOG_B = 2;

    typedef struct packed {
        logic [7:0] rd_data;
    } rd_state_t;

endpackage

// File: rtl/flash_stat_toggle.sv
module flash_stat_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    output logic q
);
    logic tog_d, tog_q;

    always_comb begin
        tog_d = tog_q;
        if (clr)      tog_d = 1'b0;
        else if (adv) tog_d = ~tog_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tog_q <= 1'b0;
        else        tog_q <= tog_d;
    end

    assign q = tog_q;

    // R10: a start pulse leaves the flip-flop cleared
    p_tog_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !q);
    // R5 / R6: each qualified read flips the bit
    p_tog_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr) |=> (q != $past(q)));
    // R6 / R7: no qualified read, no change
    p_tog_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !clr) |=> $stable(q));
endmodule

// File: rtl/flash_stat_sect.sv
module flash_stat_sect #(
    parameter int unsigned ADDR_W = 19,
    parameter int unsigned SECT_W = 3,
    localparam int unsigned NSECT = 1 << SECT_W,
    localparam int unsigned SHIFT = ADDR_W - SECT_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [NSECT-1:0]  sel_mask,
    input  logic              all_sel,
    output logic              hit
);
    logic [SECT_W-1:0] idx;
    logic [NSECT-1:0]  onehot;

    assign idx = SECT_W'(addr >> SHIFT);

    for (genvar i = 0; i < NSECT; i++) begin : g_dec
        assign onehot[i] = (idx == SECT_W'(i));
    end

    assign hit = all_sel | (|(onehot & sel_mask));
endmodule

// File: rtl/flash_stat_enc.sv
module flash_stat_enc
    import flash_stat_pkg::*;
(
    input  emb_op_e    op,
    input  logic       done,
    input  logic       tmo,
    input  logic       prog_msb,
    input  logic       sect_hit,
    input  logic       tog_a,
    input  logic       tog_b,
    input  logic [7:0] arr,
    output logic [7:0] byte_o
);
    always_comb begin
        byte_o = arr;
        unique case (op)
            OP_PROG: begin
                if (!done) begin
                    byte_o            = 8'h00;
                    byte_o[BIT_POLL]  = ~prog_msb;
                    byte_o[BIT_TOG_A] = tog_a;
                    byte_o[BIT_TMO]   = tmo;
                    byte_o[BIT_TOG_B] = 1'b1;
                end
            end
            OP_CHIP_ERASE, OP_SECT_ERASE: begin
                if (!done) begin
                    byte_o            = 8'h00;
                    byte_o[BIT_TOG_A] = tog_a;
                    byte_o[BIT_TMO]   = tmo;
                    byte_o[BIT_TOG_B] = sect_hit ? tog_b : 1'b1;
                end
            end
            OP_SUSPEND: begin
                if (sect_hit) begin
                    byte_o            = 8'h00;
                    byte_o[BIT_POLL]  = 1'b1;
                    byte_o[BIT_TOG_A] = 1'b1;
                    byte_o[BIT_TOG_B] = tog_b;
                end
            end
            default: byte_o = arr;
        endcase
    end
endmodule

// File: rtl/flash_stat_gen.sv
module flash_stat_gen
    import flash_stat_pkg::*;
#(
    parameter int unsigned ADDR_W = 19,
    parameter int unsigned SECT_W = 3,
    localparam int unsigned NSECT = 1 << SECT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op,
    input  logic              op_start,
    input  logic              op_done,
    input  logic              op_timeout,
    input  logic              prog_msb,
    input  logic              rd_strobe,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [NSECT-1:0]  erase_sel,
    input  logic [7:0]        array_data,
    output logic [7:0]        rd_data
);
    emb_op_e   op_e;
    logic      is_erase, busy, sect_hit;
    logic      tog_a, tog_b, adv_a, adv_b;
    logic [7:0] status_byte;
    rd_state_t st_d, st_q;

    assign op_e     = emb_op_e'(op);
    assign is_erase = (op_e == OP_CHIP_ERASE) || (op_e == OP_SECT_ERASE);
    assign busy     = ((op_e == OP_PROG) || is_erase) && !op_done;

    flash_stat_sect #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) i_sect (
        .addr     (rd_addr),
        .sel_mask (erase_sel),
        .all_sel  (op_e == OP_CHIP_ERASE),
        .hit      (sect_hit)
    );

    assign adv_a = rd_strobe && busy;
    assign adv_b = rd_strobe && sect_hit &&
                   ((is_erase && !op_done) || (op_e == OP_SUSPEND));

    flash_stat_toggle i_tog_a (
        .clk (clk), .rst_n (rst_n), .clr (op_start), .adv (adv_a), .q (tog_a)
    );
    flash_stat_toggle i_tog_b (
        .clk (clk), .rst_n (rst_n), .clr (op_start), .adv (adv_b), .q (tog_b)
    );

    flash_stat_enc i_enc (
        .op       (op_e),
        .done     (op_done),
        .tmo      (op_timeout),
        .prog_msb (prog_msb),
        .sect_hit (sect_hit),
        .tog_a    (tog_a),
        .tog_b    (tog_b),
        .arr      (array_data),
        .byte_o   (status_byte)
    );

    always_comb begin
        st_d = st_q;
        if (rd_strobe) st_d.rd_data = status_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.rd_data;

    // R2: idle reads pass array data
    p_idle_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && op_e == OP_IDLE) |=> (rd_data == $past(array_data)));
    // R2: output holds between reads
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe |=> $stable(rd_data));
    // R3: inverted poll bit while programming
    p_prog_poll_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && op_e == OP_PROG && !op_done) |=> (rd_data[7] == ~$past(prog_msb)));
    // R4: poll bit low while erasing
    p_erase_poll_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && is_erase && !op_done) |=> (rd_data[7] == 1'b0));
    // R8: suspended sector reads show both upper status bits high
    p_susp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && op_e == OP_SUSPEND && sect_hit) |=> (rd_data[7:6] == 2'b11));
    // R9: time-limit flag reaches bit 5 while busy
    p_tmo_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && busy) |=> (rd_data[5] == $past(op_timeout)));
endmodule

// File: tb/test_flash_stat_gen.sv
module test_flash_stat_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op = 3'd0;
    logic        op_start = 1'b0, op_done = 1'b0, op_timeout = 1'b0, prog_msb = 1'b0;
    logic        rd_strobe = 1'b0;
    logic [18:0] rd_addr = '0;
    logic [7:0]  erase_sel = '0, array_data = '0;
    logic [7:0]  rd_data;

    int n_run = 0, n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    flash_stat_gen i_flash_stat_gen (
        .clk (clk), .rst_n (rst_n), .op (op), .op_start (op_start),
        .op_done (op_done), .op_timeout (op_timeout), .prog_msb (prog_msb),
        .rd_strobe (rd_strobe), .rd_addr (rd_addr), .erase_sel (erase_sel),
        .array_data (array_data), .rd_data (rd_data)
    );

    typedef struct packed {
        logic [2:0]  op;
        logic        start;
        logic        done;
        logic        tmo;
        logic        msb;
        logic [18:0] addr;
        logic [7:0]  mask;
        logic [7:0]  arr;
        logic [7:0]  exp;
        logic [3:0]  req;
    } vec_t;

    localparam logic [18:0] A_S2 = 19'h20010;
    localparam logic [18:0] A_S5 = 19'h50000;
    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{3'd0, 1'b0, 1'b0, 1'b0, 1'b0, A_S2, 8'h04, 8'hA5, 8'hA5, 4'd2},  // R2 idle
        '{3'd1, 1'b1, 1'b0, 1'b0, 1'b0, A_S2, 8'h04, 8'h11, 8'h84, 4'd3},  // R3 program
        '{3'd1, 1'b0, 1'b0, 1'b0, 1'b0, A_S5, 8'h04, 8'h11, 8'hC4, 4'd5},  // R5 toggle A
        '{3'd1, 1'b0, 1'b0, 1'b1, 1'b1, A_S2, 8'h04, 8'h11, 8'h24, 4'd9},  // R9 time limit
        '{3'd1, 1'b0, 1'b1, 1'b0, 1'b0, A_S2, 8'h04, 8'h5A, 8'h5A, 4'd7},  // R7 done
        '{3'd1, 1'b0, 1'b0, 1'b0, 1'b0, A_S2, 8'h04, 8'h11, 8'hC4, 4'd7},  // R7 A held
        '{3'd3, 1'b1, 1'b0, 1'b0, 1'b0, A_S2, 8'h04, 8'h11, 8'h00, 4'd4},  // R4 sector erase
        '{3'd3, 1'b0, 1'b0, 1'b0, 1'b0, A_S2, 8'h04, 8'h11, 8'h44, 4'd6},  // R6 B toggles
        '{3'd3, 1'b0, 1'b0, 1'b0, 1'b0, A_S5, 8'h04, 8'h11, 8'h04, 4'd6},  // R6 unselected
        '{3'd3, 1'b0, 1'b0, 1'b0, 1'b0, A_S2, 8'h04, 8'h11, 8'h40, 4'd6},  // R6 B held
        '{3'd4, 1'b0, 1'b0, 1'b0, 1'b0, A_S2, 8'h04, 8'h11, 8'hC4, 4'd8},  // R8 suspend
        '{3'd4, 1'b0, 1'b0, 1'b0, 1'b0, A_S2, 8'h04, 8'h11, 8'hC0, 4'd8},  // R8 B toggles
        '{3'd4, 1'b0, 1'b0, 1'b0, 1'b0, A_S5, 8'h04, 8'h77, 8'h77, 4'd8},  // R8 other sector
        '{3'd3, 1'b0, 1'b0, 1'b1, 1'b0, A_S2, 8'h04, 8'h11, 8'h24, 4'd9},  // R9 resume
        '{3'd2, 1'b1, 1'b0, 1'b0, 1'b0, A_S5, 8'h04, 8'h11, 8'h00, 4'd4},  // R4 chip erase
        '{3'd2, 1'b0, 1'b0, 1'b0, 1'b0, A_S5, 8'h04, 8'h11, 8'h44, 4'd4},  // R4 mask ignored
        '{3'd2, 1'b0, 1'b1, 1'b0, 1'b0, A_S5, 8'h04, 8'hFF, 8'hFF, 4'd7},  // R7 erase done
        '{3'd0, 1'b0, 1'b0, 1'b0, 1'b0, A_S2, 8'h04, 8'h00, 8'h00, 4'd2}   // R2 idle
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic do_read(input logic start_with);
        op_start  = start_with;
        rd_strobe = 1'b1;
        @(negedge clk);
        op_start  = 1'b0;
        rd_strobe = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", rd_data, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", rd_data, 8'h00);

        for (int i = 0; i < NV; i++) begin
            op = VEC[i].op; op_done = VEC[i].done; op_timeout = VEC[i].tmo;
            prog_msb = VEC[i].msb; rd_addr = VEC[i].addr;
            erase_sel = VEC[i].mask; array_data = VEC[i].arr;
            if (VEC[i].start) begin
                op_start = 1'b1;
                @(negedge clk);
                op_start = 1'b0;
            end
            do_read(1'b0);
            check($sformatf("R%0d vector %0d", VEC[i].req, i), rd_data, VEC[i].exp);
        end

        // R2: no strobe, inputs change, output holds
        array_data = 8'h3C; op = 3'd1;
        repeat (3) @(negedge clk);
        check("R2 hold", rd_data, 8'h00);

        // R10: start together with a read clears after that read
        op = 3'd1; op_done = 1'b0; op_timeout = 1'b0; prog_msb = 1'b0;
        do_read(1'b0);
        check("R10 pre read", rd_data, 8'h84);
        do_read(1'b1);
        check("R10 read with start", rd_data, 8'hC4);
        do_read(1'b0);
        check("R10 cleared", rd_data, 8'h84);

        // R1: reset mid-operation clears output and toggles
        do_read(1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid reset", rd_data, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        do_read(1'b0);
        check("R1 toggle cleared", rd_data, 8'h84);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule